// File: doc/BRIEF.md
# USB IN-Endpoint Interrupt Status Hierarchy

This block keeps one interrupt status register for each of four USB device IN endpoints and folds them into a per-endpoint summary vector and one core-level IN-endpoint interrupt line. The endpoint engine reports events as single-cycle pulses: transfer done, endpoint disabled, IN-token timeout, IN token with an empty TxFIFO, and NAK taking effect. The block latches each of these as a sticky flag. A live bit reports whether the endpoint's TxFIFO has drained past a threshold, and a configuration input picks that threshold.

Software reaches the status registers through a simple register port. Reads return data one cycle after the request. Most flags are cleared by writing 1 to them. The NAK-effective flag is different: it is cleared only by a clear-NAK command pulse from the endpoint control logic. Interrupt masking is not modelled, so every source is treated as enabled.

Top module: `usb_inep_irq_hier`

## Requirements
- R1: After reset every sticky flag is 0, so with an empty TxFIFO each endpoint register reads 0x0000_0080, every summary bit is 1 and the interrupt line is 1.
- R2: Endpoint n's register sits at address 0x908 + n*0x20. Read data appears on the clock edge after the read request and shows the value held before that edge. A read of any other address returns 0.
- R3: Bit 7 (FIFO empty) is live and read-only. With empty_lvl_sel=0 it is 1 when the FIFO fill count is at most FIFO_DEPTH/2. With empty_lvl_sel=1 it is 1 only when the fill count is 0.
- R4: Bit 6 (NAK effective) is set by ev_nak_seen[n] and cleared only by cmd_clr_nak[n]. Writing 1 to bit 6 has no effect.
- R5: Bit 4 (IN token while the FIFO is empty) is set by ev_tok_empty[n] only when ep_periodic[n] is 0.
- R6: Bit 3 (timeout) exists only on endpoint 0 and is set by ev_timeout_ep0. It always reads 0 on endpoints 1 to 3.
- R7: Bits 0 (transfer done, ev_xfer_done), 1 (disabled, ev_ep_dis), 3 and 4 are sticky and are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R8: Bits 31:8, 5 and 2 always read 0 and ignore writes.
- R9: ep_sum[n] is the OR of endpoint n's sticky flags and its bit 7. in_ep_irq is the OR of ep_sum. Clearing an endpoint's last source drops its summary bit, and the line drops once no summary bit is left.
- R10: When an event pulse and a clear (a write of 1, or the clear-NAK command) hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_xfer_done | input | NUM_EP | Transfer-complete pulse per endpoint |
| ev_ep_dis | input | NUM_EP | Endpoint-disabled pulse per endpoint |
| ev_tok_empty | input | NUM_EP | IN token received with an empty FIFO, per endpoint |
| ev_timeout_ep0 | input | 1 | IN-token timeout on control endpoint 0 |
| ev_nak_seen | input | NUM_EP | NAK bit sampled as set, per endpoint |
| cmd_clr_nak | input | NUM_EP | Clear-NAK command pulse per endpoint |
| ep_periodic | input | NUM_EP | Endpoint is periodic (configuration) |
| fifo_used | input | NUM_EP*LVL_W | TxFIFO fill counts, endpoint n in slice n |
| empty_lvl_sel | input | 1 | 0: half-empty threshold, 1: fully-empty threshold |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| ep_sum | output | NUM_EP | Per-endpoint summary bits |
| in_ep_irq | output | 1 | Core-level IN-endpoint interrupt |

## Verification
The bench runs random event pulses, clears and writes of random bit patterns against a bench model, with random FIFO levels and threshold selections. Mismatches in the read data separate wrong bit positions, address decoding and read latency. Mismatches in the summary bits separate wrong roll-up logic from wrong flag storage. Directed cases cover the exact threshold points (count at FIFO_DEPTH/2 and one above, count 1 and 0), the periodic and non-periodic handling of bit 4, writes of 1 to bit 6, and event-versus-clear collisions. A final case clears every endpoint, which shows whether the interrupt line actually falls.

// File: rtl/usb_inep_irq_hier.sv
module usb_inep_irq_hier #(
  parameter int NUM_EP     = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter logic [11:0] BASE   = 12'h908,
  parameter logic [11:0] STRIDE = 12'h020
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EP-1:0]        ev_xfer_done,
  input  logic [NUM_EP-1:0]        ev_ep_dis,
  input  logic [NUM_EP-1:0]        ev_tok_empty,
  input  logic                     ev_timeout_ep0,
  input  logic [NUM_EP-1:0]        ev_nak_seen,
  input  logic [NUM_EP-1:0]        cmd_clr_nak,
  input  logic [NUM_EP-1:0]        ep_periodic,
  input  logic [NUM_EP*LVL_W-1:0]  fifo_used,
  input  logic                     empty_lvl_sel,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [11:0]              reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic [NUM_EP-1:0]        ep_sum,
  output logic                     in_ep_irq
);
  localparam logic [LVL_W-1:0] HALF  = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [6:0]       W1C_M = 7'h1B;
  localparam logic [6:0]       NAK_M = 7'h40;

  logic [NUM_EP-1:0][6:0] flags;
  logic [NUM_EP-1:0]      fe;
  logic [NUM_EP-1:0]      hit;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic [LVL_W-1:0] lvl;
    logic [6:0] set_v, clr_v;
    assign lvl    = fifo_used[g*LVL_W +: LVL_W];
    assign hit[g] = reg_addr == 12'(BASE + g * STRIDE);
    assign fe[g]  = empty_lvl_sel ? (lvl == '0) : (lvl <= HALF);
    assign set_v  = {ev_nak_seen[g], 1'b0, ev_tok_empty[g] & ~ep_periodic[g],
                     (g == 0) ? ev_timeout_ep0 : 1'b0, 1'b0, ev_ep_dis[g], ev_xfer_done[g]};
    assign clr_v  = ((reg_wr && hit[g]) ? (reg_wdata[6:0] & W1C_M) : 7'h0)
                  | (cmd_clr_nak[g] ? NAK_M : 7'h0);

    always_ff @(posedge clk)
      if (!rst_n) flags[g] <= '0;
      else        flags[g] <= (flags[g] & ~clr_v) | set_v;

    assign ep_sum[g] = (|flags[g]) | fe[g];
  end

  assign in_ep_irq = |ep_sum;

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int e = 0; e < NUM_EP; e++)
      if (hit[e]) rd_next = {24'h0, fe[e], flags[e]};
  end

  always_ff @(posedge clk)
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
    else             reg_rdata <= '0;
endmodule

// File: rtl/usb_inep_irq_chk.sv
module usb_inep_irq_chk #(
  parameter int NUM_EP = 4,
  parameter int LVL_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_EP-1:0]       ev_xfer_done,
  input logic [NUM_EP-1:0]       cmd_clr_nak,
  input logic [NUM_EP*LVL_W-1:0] fifo_used,
  input logic                    empty_lvl_sel,
  input logic                    reg_wr,
  input logic                    reg_rd,
  input logic [11:0]             reg_addr,
  input logic [31:0]             reg_wdata,
  input logic [31:0]             reg_rdata,
  input logic [NUM_EP-1:0]       ep_sum,
  input logic                    in_ep_irq
);
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:8] == 24'h0 && !reg_rdata[5] && !reg_rdata[2]);

  assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[4:0] != 5'h08) |=> reg_rdata == 32'h0);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_a
    assert_event_raises_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_xfer_done[i] |=> (ep_sum[i] && in_ep_irq));
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer_done[0] && reg_wr && reg_addr == 12'h908 && reg_wdata[0]) |=> ep_sum[0]);

  assert_irq_fall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ep_irq) |-> ($past(reg_wr) || $past(|cmd_clr_nak) ||
                          !$stable(fifo_used) || !$stable(empty_lvl_sel)));
endmodule

bind usb_inep_irq_hier usb_inep_irq_chk #(.NUM_EP(NUM_EP), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_xfer_done(ev_xfer_done), .cmd_clr_nak(cmd_clr_nak),
  .fifo_used(fifo_used), .empty_lvl_sel(empty_lvl_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ep_sum(ep_sum),
  .in_ep_irq(in_ep_irq));

// File: tb/usb_inep_irq_hier_tb.sv
module usb_inep_irq_hier_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 4;
  localparam int FIFO_DEPTH = 16;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [NUM_EP-1:0] ev_xfer_done = 0, ev_ep_dis = 0, ev_tok_empty = 0, ev_nak_seen = 0;
  logic [NUM_EP-1:0] cmd_clr_nak = 0, ep_periodic = 0;
  logic ev_timeout_ep0 = 0, empty_lvl_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [NUM_EP*LVL_W-1:0] fifo_used = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NUM_EP-1:0] ep_sum;
  logic in_ep_irq;

  int checks = 0, errors = 0;
  logic [6:0] m [NUM_EP];
  logic [31:0] exp_rd;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_inep_irq_hier #(.NUM_EP(NUM_EP), .FIFO_DEPTH(FIFO_DEPTH)) dut_i (.*);

  function automatic logic [11:0] ep_addr(int e);
    return 12'h908 + 12'(e * 32);
  endfunction

  function automatic logic fe_f(int e);
    logic [LVL_W-1:0] u = fifo_used[e*LVL_W +: LVL_W];
    return empty_lvl_sel ? (u == 0) : (u <= LVL_W'(FIFO_DEPTH/2));
  endfunction

  function automatic logic [31:0] view_f(int e);
    return {24'h0, fe_f(e), m[e]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_lvl(int e, int v);
    fifo_used[e*LVL_W +: LVL_W] = LVL_W'(v);
  endtask

  task automatic tick(string rq = "R2", bit chk_sum = 1);
    @(posedge clk);
    exp_rd = 0;
    if (reg_rd) for (int e = 0; e < NUM_EP; e++) if (reg_addr == ep_addr(e)) exp_rd = view_f(e);
    for (int e = 0; e < NUM_EP; e++) begin
      logic [6:0] clr, st;
      clr = ((reg_wr && reg_addr == ep_addr(e)) ? (reg_wdata[6:0] & 7'h1B) : 7'h0)
          | (cmd_clr_nak[e] ? 7'h40 : 7'h0);
      st = {ev_nak_seen[e], 1'b0, ev_tok_empty[e] & ~ep_periodic[e],
            (e == 0) ? ev_timeout_ep0 : 1'b0, 1'b0, ev_ep_dis[e], ev_xfer_done[e]};
      m[e] = (m[e] & ~clr) | st;
    end
    @(negedge clk);
    if (reg_rd) check(rq, reg_rdata, exp_rd);
    if (chk_sum) begin
      logic [NUM_EP-1:0] es;
      for (int e = 0; e < NUM_EP; e++) es[e] = (|m[e]) | fe_f(e);
      check("R9 sum", {28'h0, ep_sum}, {28'h0, es});
      check("R9 irq", {31'h0, in_ep_irq}, {31'h0, |es});
    end
    ev_xfer_done = 0; ev_ep_dis = 0; ev_tok_empty = 0; ev_nak_seen = 0;
    cmd_clr_nak = 0; ev_timeout_ep0 = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic rd(int e, string rq);
    reg_rd = 1; reg_addr = ep_addr(e); tick(rq);
  endtask

  task automatic wr(int e, logic [31:0] d, string rq);
    reg_wr = 1; reg_addr = ep_addr(e); reg_wdata = d; tick(rq);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    for (int e = 0; e < NUM_EP; e++) m[e] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state with empty FIFOs
    check("R1 sum", {28'h0, ep_sum}, 32'hF);
    check("R1 irq", {31'h0, in_ep_irq}, 1);
    for (int e = 0; e < NUM_EP; e++) rd(e, "R1");
    // R2 unmapped address
    reg_rd = 1; reg_addr = 12'h90C; tick("R2 unmapped");
    // R3 thresholds
    set_lvl(1, FIFO_DEPTH/2); rd(1, "R3 half");
    set_lvl(1, FIFO_DEPTH/2 + 1); rd(1, "R3 over half");
    empty_lvl_sel = 1; set_lvl(1, 1); rd(1, "R3 one left");
    set_lvl(1, 0); rd(1, "R3 empty");
    wr(1, 32'h80, "R3 ro"); rd(1, "R3 ro");
    empty_lvl_sel = 0;
    for (int e = 0; e < NUM_EP; e++) set_lvl(e, FIFO_DEPTH);
    // R4 NAK effective
    ev_nak_seen[2] = 1; tick("R4");
    wr(2, 32'h40, "R4"); rd(2, "R4 w1 ignored");
    cmd_clr_nak[2] = 1; tick("R4"); rd(2, "R4 cleared");
    // R5 periodic endpoint
    ep_periodic = 4'b1000; ev_tok_empty = 4'b1001; tick("R5");
    rd(3, "R5 periodic"); rd(0, "R5 nonperiodic");
    // R6 timeout only ep0
    ev_timeout_ep0 = 1; tick("R6"); rd(0, "R6");
    // R7 / R8 write patterns
    ev_xfer_done[1] = 1; ev_ep_dis[1] = 1; tick("R7");
    wr(1, 32'h0, "R7 zero"); rd(1, "R7 kept");
    wr(1, 32'hFFFF_FF25, "R8"); rd(1, "R8 partial clear");
    // R10 collision
    ev_xfer_done[1] = 1; reg_wr = 1; reg_addr = ep_addr(1); reg_wdata = 32'h3; tick("R10");
    rd(1, "R10 set wins");
    ev_nak_seen[0] = 1; cmd_clr_nak[0] = 1; tick("R10"); rd(0, "R10 nak set wins");
    // random
    for (int i = 0; i < 400; i++) begin
      ev_xfer_done = 4'($urandom) & 4'($urandom) & 4'($urandom);
      ev_ep_dis = 4'($urandom) & 4'($urandom) & 4'($urandom);
      ev_tok_empty = 4'($urandom) & 4'($urandom);
      ev_nak_seen = 4'($urandom) & 4'($urandom) & 4'($urandom);
      cmd_clr_nak = 4'($urandom) & 4'($urandom);
      ev_timeout_ep0 = ($urandom % 6) == 0;
      ep_periodic = 4'($urandom);
      if ($urandom % 4 == 0) empty_lvl_sel = 1'($urandom);
      for (int e = 0; e < NUM_EP; e++) if ($urandom % 3 == 0) set_lvl(e, $urandom % (FIFO_DEPTH + 1));
      reg_wr = 1'($urandom); reg_rd = 1'($urandom);
      reg_addr = ($urandom % 8 == 0) ? 12'($urandom) : ep_addr($urandom % NUM_EP);
      reg_wdata = $urandom;
      tick("R2 R7 random");
    end
    // R9 clear everything, irq must drop
    for (int e = 0; e < NUM_EP; e++) set_lvl(e, FIFO_DEPTH);
    empty_lvl_sel = 0; tick("R9");
    cmd_clr_nak = 4'hF; tick("R9");
    for (int e = 0; e < NUM_EP; e++) wr(e, 32'hFF, "R9");
    check("R9 irq low", {31'h0, in_ep_irq}, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule